// File: doc/BRIEF.md
# Synchronous Flow-Through Burst SRAM

This block is a single-clock static memory whose reads flow straight from the array to the output port, with no output register. Every address, control and write-data input is captured on the rising clock edge. A new access begins when either of two active-low address strobes is sampled low while all three chip selects are asserted. One strobe is meant for a processor and the other for a cache controller. The external address is loaded as the burst base. An internal two-bit counter then supplies the two low address bits. Each cycle with the active-low advance input low steps the counter, and it wraps after four words. A mode input picks interleaved order (start XOR count) or linear order (start plus count, modulo four, inside an aligned group of four words).

Writes are either whole-word, through an active-low global write enable, or per-lane, through an active-low byte write enable qualified by active-low lane enables. A cycle started by the processor strobe is always a read. The data bus is shown as separate input, output and output-enable ports. The output enable follows the active-low output-enable pin without a clock. A high sleep input freezes every register and the array contents until sleep is released.

Top module: `sync_burst_sram`

## Requirements
- R1: An edge with procStrobeN or ctrlStrobeN low and all chip selects asserted (chipSelN=0, chipSelHi=1, chipSel2N=0) loads addrIn as the base, clears the burst count and selects the chip. The next cycle reads the word at addrIn.
- R2: An edge with a strobe low and any chip select deasserted deselects the chip. While deselected, dataOe is low, the advance input does nothing and no write takes place.
- R3: With both strobes high, advanceN low on a selected chip increments the count modulo 4. With advanceN high the current address is held and the same word is accessed again.
- R4: With linearMode=0 the two low address bits equal the base's low bits XOR the count, and the upper bits come from the base.
- R5: With linearMode=1 the two low address bits equal the base's low bits plus the count, modulo 4, and the upper bits come from the base.
- R6: globalWrN=0 on a write-eligible edge writes every lane of dataIn, whatever byteWrEnN and laneWrN are.
- R7: With globalWrN=1 and byteWrEnN=0, lane i (bits [i*LANE_W +: LANE_W]) is written exactly when laneWrN[i]=0. With globalWrN=1 and byteWrEnN=1, nothing is written.
- R8: An edge at which procStrobeN is low writes nothing. An edge at which only ctrlStrobeN is low may write to the newly loaded address.
- R9: A write-eligible edge stores data at the address that is current after that edge: the address after any load or advance at the same edge. dataOut shows the array word at the current address with no register in between, so written data is visible right after the writing edge.
- R10: dataOe is high exactly when outEnN is low, the chip is selected and sleep is low.
- R11: While sleep is high, edges change neither the address, the count, the selection nor the array contents. Normal operation resumes when sleep goes low.
- R12: A synchronous active-low reset deselects the chip, clears the count and base, and holds dataOe low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset of control state, active low |
| addrIn | input | ADDR_W | Word address loaded by a strobe |
| dataIn | input | LANES*LANE_W | Write data |
| procStrobeN | input | 1 | Processor address strobe, active low, read-only start |
| ctrlStrobeN | input | 1 | Controller address strobe, active low |
| advanceN | input | 1 | Burst advance, active low |
| chipSelN | input | 1 | Chip select, active low |
| chipSelHi | input | 1 | Chip select, active high |
| chipSel2N | input | 1 | Second chip select, active low |
| globalWrN | input | 1 | Whole-word write, active low |
| byteWrEnN | input | 1 | Lane write qualifier, active low |
| laneWrN | input | LANES | Per-lane write enables, active low |
| outEnN | input | 1 | Output enable, active low, unclocked |
| linearMode | input | 1 | 1 selects linear burst order, 0 interleaved |
| sleep | input | 1 | Power-down, freezes state while high |
| dataOut | output | LANES*LANE_W | Read data, valid while dataOe is high |
| dataOe | output | 1 | Drive enable of the data bus |

## Verification
The bench builds the block with ADDR_W=5, LANES=4 and LANE_W=9, which gives a 32-word by 36-bit memory. With only 32 words, a short sequence of bursts fills the whole array, so every read compares against a known word. Four 9-bit lanes let single and mixed lane masks be checked at the lane boundaries. Five address bits leave three upper bits, enough to show that both burst orders keep the upper bits fixed while wrapping from any starting offset.

// File: rtl/sram_burst_pkg.sv
package sram_burst_pkg;

  // Strobes handed from the control to the datapath each cycle
  typedef struct packed {
    logic       load;       // base register takes addrIn at this edge
    logic [1:0] curCount;   // burst count in effect this cycle
    logic [1:0] nextCount;  // burst count after this edge
  } burstStrb_t;

  // Low address bits for a burst step
  function automatic logic [1:0] burstLow(input logic [1:0] startLow,
                                          input logic [1:0] cnt,
                                          input logic       linear);
    return linear ? (startLow + cnt) : (startLow ^ cnt);
  endfunction

endpackage

// File: rtl/sbs_ctrl.sv
module sbs_ctrl
  import sram_burst_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             procStrobeN,
  input  logic             ctrlStrobeN,
  input  logic             advanceN,
  input  logic             chipSelN,
  input  logic             chipSelHi,
  input  logic             chipSel2N,
  input  logic             globalWrN,
  input  logic             byteWrEnN,
  input  logic [LANES-1:0] laneWrN,
  input  logic             sleep,
  output burstStrb_t       strb,
  output logic [LANES-1:0] laneMask,
  output logic             active
);

  logic             activeQ;
  logic [1:0]       countQ;
  logic             nextActive;
  logic [1:0]       nextCount;
  logic             loadNow;
  logic             selected;
  logic             anyStrobe;
  logic [LANES-1:0] laneReq;

  always_comb begin
    selected   = !chipSelN && chipSelHi && !chipSel2N;
    anyStrobe  = !procStrobeN || !ctrlStrobeN;
    loadNow    = 1'b0;
    nextActive = activeQ;
    nextCount  = countQ;
    if (!sleep) begin
      if (anyStrobe) begin
        if (selected) begin
          loadNow    = 1'b1;
          nextActive = 1'b1;
          nextCount  = 2'd0;
        end else begin
          nextActive = 1'b0;
        end
      end else if (!advanceN && activeQ) begin
        nextCount = countQ + 2'd1;
      end
    end
  end

  always_comb begin
    if (!globalWrN)      laneReq = '1;
    else if (!byteWrEnN) laneReq = ~laneWrN;
    else                 laneReq = '0;
    laneMask = (!sleep && nextActive && procStrobeN) ? laneReq : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeQ <= 1'b0;
      countQ  <= 2'd0;
    end else begin
      activeQ <= nextActive;
      countQ  <= nextCount;
    end
  end

  assign strb.load      = loadNow;
  assign strb.curCount  = countQ;
  assign strb.nextCount = nextCount;
  assign active         = activeQ;

  p_sleep_freeze_r11: assert property (@(posedge clk) disable iff (!rstN)
    sleep |=> ($stable(countQ) && $stable(activeQ)));

  p_advance_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!sleep && procStrobeN && ctrlStrobeN && !advanceN && activeQ)
      |=> (countQ == $past(countQ) + 2'd1));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!sleep && procStrobeN && ctrlStrobeN && advanceN) |=> $stable(countQ));

  p_deselect_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!sleep && (!procStrobeN || !ctrlStrobeN) &&
     !(!chipSelN && chipSelHi && !chipSel2N)) |=> !activeQ);

  p_start_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!sleep && (!procStrobeN || !ctrlStrobeN) &&
     !chipSelN && chipSelHi && !chipSel2N) |=> (activeQ && countQ == 2'd0));

  p_proc_read_r8: assert property (@(posedge clk) disable iff (!rstN)
    !procStrobeN |-> (laneMask == '0));

endmodule

// File: rtl/sbs_datapath.sv
module sbs_datapath
  import sram_burst_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  burstStrb_t              strb,
  input  logic [LANES-1:0]        laneMask,
  input  logic [ADDR_W-1:0]       addrIn,
  input  logic [LANES*LANE_W-1:0] dataIn,
  input  logic                    linearMode,
  output logic [LANES*LANE_W-1:0] rdData
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [ADDR_W-1:0] baseQ;
  logic [ADDR_W-1:0] nextBase;
  logic [ADDR_W-1:0] wrAddr;
  logic [ADDR_W-1:0] rdAddr;

  always_comb begin
    nextBase = strb.load ? addrIn : baseQ;
    wrAddr   = {nextBase[ADDR_W-1:2],
                burstLow(nextBase[1:0], strb.nextCount, linearMode)};
    rdAddr   = {baseQ[ADDR_W-1:2],
                burstLow(baseQ[1:0], strb.curCount, linearMode)};
  end

  always_ff @(posedge clk) begin
    if (!rstN)          baseQ <= '0;
    else if (strb.load) baseQ <= addrIn;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] laneMem [DEPTH];

    always_ff @(posedge clk) begin
      if (laneMask[g]) laneMem[wrAddr] <= dataIn[g*LANE_W +: LANE_W];
    end

    assign rdData[g*LANE_W +: LANE_W] = laneMem[rdAddr];
  end

  p_load_base_r1: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (baseQ == $past(addrIn)));

  p_base_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> $stable(baseQ));

endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
  import sram_burst_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-1:0]       addrIn,
  input  logic [LANES*LANE_W-1:0] dataIn,
  input  logic                    procStrobeN,
  input  logic                    ctrlStrobeN,
  input  logic                    advanceN,
  input  logic                    chipSelN,
  input  logic                    chipSelHi,
  input  logic                    chipSel2N,
  input  logic                    globalWrN,
  input  logic                    byteWrEnN,
  input  logic [LANES-1:0]        laneWrN,
  input  logic                    outEnN,
  input  logic                    linearMode,
  input  logic                    sleep,
  output logic [LANES*LANE_W-1:0] dataOut,
  output logic                    dataOe
);

  burstStrb_t       strb;
  logic [LANES-1:0] laneMask;
  logic             active;

  sbs_ctrl #(.LANES(LANES)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .procStrobeN(procStrobeN),
    .ctrlStrobeN(ctrlStrobeN),
    .advanceN   (advanceN),
    .chipSelN   (chipSelN),
    .chipSelHi  (chipSelHi),
    .chipSel2N  (chipSel2N),
    .globalWrN  (globalWrN),
    .byteWrEnN  (byteWrEnN),
    .laneWrN    (laneWrN),
    .sleep      (sleep),
    .strb       (strb),
    .laneMask   (laneMask),
    .active     (active)
  );

  sbs_datapath #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .laneMask  (laneMask),
    .addrIn    (addrIn),
    .dataIn    (dataIn),
    .linearMode(linearMode),
    .rdData    (dataOut)
  );

  assign dataOe = !outEnN && active && !sleep;

  p_sleep_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    sleep |-> !dataOe);

  p_oe_pin_r10: assert property (@(posedge clk) disable iff (!rstN)
    outEnN |-> !dataOe);

endmodule

// File: tb/sync_burst_sram_tb.sv
`timescale 1ns/1ps
module sync_burst_sram_tb;

  localparam int AW = 5;
  localparam int LN = 4;
  localparam int LW = 9;
  localparam int DW = LN*LW;
  localparam int DP = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN;
  logic [AW-1:0] addrIn;
  logic [DW-1:0] dataIn;
  logic          procStrobeN, ctrlStrobeN, advanceN;
  logic          chipSelN, chipSelHi, chipSel2N;
  logic          globalWrN, byteWrEnN;
  logic [LN-1:0] laneWrN;
  logic          outEnN, linearMode, sleep;
  logic [DW-1:0] dataOut;
  logic          dataOe;

  always #2 clk = ~clk;

  sync_burst_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) u_dut (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .dataIn(dataIn),
    .procStrobeN(procStrobeN), .ctrlStrobeN(ctrlStrobeN), .advanceN(advanceN),
    .chipSelN(chipSelN), .chipSelHi(chipSelHi), .chipSel2N(chipSel2N),
    .globalWrN(globalWrN), .byteWrEnN(byteWrEnN), .laneWrN(laneWrN),
    .outEnN(outEnN), .linearMode(linearMode), .sleep(sleep),
    .dataOut(dataOut), .dataOe(dataOe)
  );

  // reference model state
  logic [DW-1:0] mMem [DP];
  bit            mKnown [DP][LN];
  int            mBase, mCount;
  bit            mActive;
  int            checks = 0;
  int            errors = 0;
  bit            done = 0;

  function automatic int modelAddr(int base, int cnt, bit lin);
    int lo;
    lo = lin ? ((base % 4) + cnt) % 4 : ((base % 4) ^ cnt);
    return (base / 4) * 4 + lo;
  endfunction

  task automatic setIdle();
    procStrobeN = 1; ctrlStrobeN = 1; advanceN = 1;
    chipSelN = 0; chipSelHi = 1; chipSel2N = 0;
    globalWrN = 1; byteWrEnN = 1; laneWrN = '1;
    outEnN = 0; sleep = 0;
  endtask

  // advance model over one edge, then compare outputs after the edge
  task automatic tick(input string tag);
    bit sel, strobe, expOe;
    int wa;
    logic [LN-1:0] mask;
    sel    = !chipSelN && chipSelHi && !chipSel2N;
    strobe = !procStrobeN || !ctrlStrobeN;
    mask   = '0;
    @(posedge clk);
    if (!rstN) begin
      mActive = 0; mCount = 0; mBase = 0;
    end else if (!sleep) begin
      if (strobe) begin
        if (sel) begin mBase = int'(addrIn); mCount = 0; mActive = 1; end
        else mActive = 0;
      end else if (!advanceN && mActive) begin
        mCount = (mCount + 1) % 4;
      end
      if (mActive && procStrobeN) begin
        if (!globalWrN) mask = '1;
        else if (!byteWrEnN) mask = ~laneWrN;
        wa = modelAddr(mBase, mCount, linearMode);
        for (int i = 0; i < LN; i++) if (mask[i]) begin
          mMem[wa][i*LW +: LW] = dataIn[i*LW +: LW];
          mKnown[wa][i] = 1;
        end
      end
    end
    #1;
    expOe = !outEnN && mActive && !sleep;
    checks++;
    if (dataOe !== expOe) begin
      errors++;
      $display("FAIL %s: dataOe=%0b expected %0b", tag, dataOe, expOe);
    end
    if (expOe && dataOe) begin
      wa = modelAddr(mBase, mCount, linearMode);
      checks++;
      for (int i = 0; i < LN; i++) if (mKnown[wa][i] &&
          dataOut[i*LW +: LW] !== mMem[wa][i*LW +: LW]) begin
        errors++;
        $display("FAIL %s: addr %0d lane %0d dataOut=%h expected %h",
                 tag, wa, i, dataOut[i*LW +: LW], mMem[wa][i*LW +: LW]);
      end
    end
    @(negedge clk);
  endtask

  initial begin
    #(4*150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < DP; a++) for (int l = 0; l < LN; l++) mKnown[a][l] = 0;
    mBase = 0; mCount = 0; mActive = 0;
    setIdle();
    rstN = 0; linearMode = 1; addrIn = '0; dataIn = '0;
    @(negedge clk);
    // R12: reset holds the chip deselected
    repeat (3) tick("R12");
    rstN = 1;
    tick("R12");

    // R6: fill the array with whole-word linear bursts via the controller strobe
    for (int b = 0; b < DP; b += 4) begin
      ctrlStrobeN = 0; addrIn = AW'(b); globalWrN = 0;
      dataIn = {$urandom, $urandom}; laneWrN = 4'b0101;
      tick("R6");
      ctrlStrobeN = 1; advanceN = 0;
      for (int k = 0; k < 3; k++) begin dataIn = {$urandom, $urandom}; tick("R6"); end
      setIdle();
    end

    // R1/R8: processor strobe start, write enables low are ignored
    procStrobeN = 0; addrIn = 5'd13; globalWrN = 0; dataIn = '1;
    tick("R8");
    setIdle(); advanceN = 0;
    // R5: linear order from offset 1 wraps inside the group of four
    repeat (3) tick("R5");
    tick("R3");               // fifth step wraps to the start word
    advanceN = 1;
    repeat (2) tick("R3");    // hold
    procStrobeN = 0; addrIn = 5'd22; tick("R1");
    setIdle(); advanceN = 0; repeat (4) tick("R5");

    // R2: each chip select deselects; advance and writes then do nothing
    setIdle(); ctrlStrobeN = 0; chipSelN = 1; tick("R2");
    setIdle(); advanceN = 0; globalWrN = 0; dataIn = '0; repeat (2) tick("R2");
    setIdle(); procStrobeN = 0; chipSelHi = 0; tick("R2");
    setIdle(); ctrlStrobeN = 0; chipSel2N = 1; globalWrN = 0; tick("R2");
    linearMode = 0;           // change order only while deselected

    // R4: interleaved order from offset 2 and offset 3
    setIdle(); procStrobeN = 0; addrIn = 5'd6; tick("R4");
    setIdle(); advanceN = 0; repeat (4) tick("R4");
    setIdle(); procStrobeN = 0; addrIn = 5'd27; tick("R4");
    setIdle(); advanceN = 0; repeat (3) tick("R4");

    // R7: lane writes through the controller strobe, then read back (R9)
    setIdle(); ctrlStrobeN = 0; addrIn = 5'd21; byteWrEnN = 0;
    laneWrN = 4'b1010; dataIn = {$urandom, $urandom}; tick("R7");
    setIdle(); advanceN = 0; byteWrEnN = 0; laneWrN = 4'b0111;
    dataIn = {$urandom, $urandom}; tick("R7");
    byteWrEnN = 1; laneWrN = 4'b0000; dataIn = '0; tick("R7");
    byteWrEnN = 0; laneWrN = 4'b1111; tick("R7");
    setIdle(); globalWrN = 0; byteWrEnN = 0; laneWrN = '1;
    dataIn = {$urandom, $urandom}; tick("R6");
    setIdle(); procStrobeN = 0; addrIn = 5'd20; tick("R9");
    setIdle(); advanceN = 0; repeat (4) tick("R9");

    // R10: output enable pin
    setIdle(); outEnN = 1; repeat (2) tick("R10");
    outEnN = 0; tick("R10");

    // R11: sleep ignores strobes, writes and advance
    setIdle(); procStrobeN = 0; addrIn = 5'd9; tick("R11");
    setIdle(); sleep = 1; ctrlStrobeN = 0; addrIn = 5'd30; globalWrN = 0;
    dataIn = '0; advanceN = 0; repeat (3) tick("R11");
    setIdle(); tick("R11");
    procStrobeN = 0; addrIn = 5'd30; tick("R11");

    // R9: random traffic with selects mostly asserted
    for (int n = 0; n < 400; n++) begin
      procStrobeN = ($urandom % 6) != 0;
      ctrlStrobeN = ($urandom % 5) != 0;
      advanceN    = $urandom % 2;
      chipSelN    = ($urandom % 10) == 0;
      chipSelHi   = ($urandom % 10) != 0;
      chipSel2N   = 0;
      globalWrN   = ($urandom % 4) != 0;
      byteWrEnN   = $urandom % 2;
      laneWrN     = LN'($urandom);
      outEnN      = ($urandom % 8) == 0;
      sleep       = ($urandom % 12) == 0;
      addrIn      = AW'($urandom);
      dataIn      = {$urandom, $urandom};
      tick("R9");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule